// File: doc/BRIEF.md
# Watchdog Timer with Keyed Restart

This block is a memory-mapped watchdog for a 32-bit register bus. A down-counter is loaded from a programmable reload register and counts only while the control register's enable bit is set. Each count step is taken either on every clock cycle or, when the control register selects it, only on cycles where an external 1 MHz tick input is high. Software proves it is alive by writing a fixed key word to the restart register, which reloads the counter. Any other word written there has no effect.

When the counter is already at zero and a count step arrives, the block emits a one-cycle expiry event and reloads the counter. In the same cycle it pulses an interrupt request and/or a system reset request, as the control bits allow. A level output reports the reset scope held in the control register (SoC or full chip). The reset pulse shaping and timeout status or clear registers sit outside this block.

Top module: `wdog_keyed_top`

## Requirements
- R1: After reset the reload register reads 0x03EF1480, the control and restart registers read 0, the status register reads 0x03EF1480, and expire_evt, irq_req, sys_rst_req and scope_full are all 0.
- R2: The byte offsets are status 0x0 (current counter, read only), reload 0x4 (read/write), restart 0x8 (always reads 0) and control 0xC. bus_rdata shows the register selected by bus_addr one cycle after the address is presented. Any other address reads 0.
- R3: The control register bits are bit 0 enable, bit 1 reset request on expiry, bit 2 interrupt on expiry, bit 4 select the 1 MHz tick, and bit 5 reset scope. All other bits are not stored and read as 0.
- R4: A control write that sets bit 0 while the enable is currently 0 loads the counter from the reload register at that same clock edge.
- R5: While enabled, the counter falls by exactly one per count step, and with bit 4 clear a step happens on every clock cycle. While disabled, the counter holds its value.
- R6: With control bit 4 set, a count step happens only on clock cycles where tick_1mhz is 1.
- R7: A count step taken at counter value 0 reloads the counter and produces a one-cycle expire_evt. With reload value N the expiries therefore come every N+1 count steps after enabling.
- R8: irq_req pulses together with expire_evt only when control bit 2 is set, and sys_rst_req only when control bit 1 is set. Neither is ever high without expire_evt.
- R9: Writing exactly 0x00004755 to the restart register reloads the counter, whether or not the counter is enabled. Writing any other word there leaves the counter unchanged. A restart write takes priority over a count step in the same cycle.
- R10: scope_full equals control bit 5 (0 = SoC reset, 1 = full-chip reset) from the cycle after the control write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data for bus_addr |
| tick_1mhz | input | 1 | One-cycle 1 MHz tick pulse |
| expire_evt | output | 1 | One-cycle expiry event |
| irq_req | output | 1 | Interrupt request pulse on expiry |
| sys_rst_req | output | 1 | System reset request pulse on expiry |
| scope_full | output | 1 | Reset scope: 1 full chip, 0 SoC |

## Verification
The bench uses the default parameters: a 32-bit counter and a 4-bit byte address. It keeps the reset reload value for the reset check and then programs reload values of 0 to 6. That makes the expiry period short enough to check cycle by cycle over two full periods, under every combination of the interrupt and reset bits. The external tick runs at one pulse every three cycles for reload values 0 to 3. The restart key is checked against near-miss words, with the counter both frozen and running, and the status reads confirm each load.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int OFS_STATUS  = 'h0;
  localparam int OFS_RELOAD  = 'h4;
  localparam int OFS_RESTART = 'h8;
  localparam int OFS_CTRL    = 'hC;

  localparam int CB_EN    = 0;
  localparam int CB_RST   = 1;
  localparam int CB_IRQ   = 2;
  localparam int CB_TSEL  = 4;
  localparam int CB_SCOPE = 5;

  localparam logic [31:0] RESTART_KEY = 32'h0000_4755;

  typedef struct packed {
    logic scope_full;
    logic tick_sel;
    logic irq_en;
    logic rst_en;
    logic en;
  } wd_ctrl_t;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32,
  parameter logic [DATA_W-1:0] RELOAD_RST = 32'h03EF_1480
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CNT_W-1:0]  cnt_val,
  output wd_ctrl_t          ctrl_q,
  output logic [DATA_W-1:0] reload_q,
  output logic              load_req,
  output logic [DATA_W-1:0] rdata
);
  logic hit_status, hit_reload, hit_restart, hit_ctrl;
  logic key_ok, en_rise;
  logic [DATA_W-1:0] ctrl_word, rd_next;

  assign hit_status  = (addr == ADDR_W'(OFS_STATUS));
  assign hit_reload  = (addr == ADDR_W'(OFS_RELOAD));
  assign hit_restart = (addr == ADDR_W'(OFS_RESTART));
  assign hit_ctrl    = (addr == ADDR_W'(OFS_CTRL));

  assign key_ok   = wr && hit_restart && (wdata == DATA_W'(RESTART_KEY));
  assign en_rise  = wr && hit_ctrl && wdata[CB_EN] && !ctrl_q.en;
  assign load_req = key_ok || en_rise;

  always_comb begin
    ctrl_word = '0;
    ctrl_word[CB_EN]    = ctrl_q.en;
    ctrl_word[CB_RST]   = ctrl_q.rst_en;
    ctrl_word[CB_IRQ]   = ctrl_q.irq_en;
    ctrl_word[CB_TSEL]  = ctrl_q.tick_sel;
    ctrl_word[CB_SCOPE] = ctrl_q.scope_full;
  end

  always_comb begin
    rd_next = '0;
    if (hit_status)      rd_next = DATA_W'(cnt_val);
    else if (hit_reload) rd_next = reload_q;
    else if (hit_ctrl)   rd_next = ctrl_word;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= '0;
      reload_q <= RELOAD_RST;
      rdata    <= '0;
    end else begin
      rdata <= rd_next;
      if (wr && hit_reload) reload_q <= wdata;
      if (wr && hit_ctrl) begin
        ctrl_q.en         <= wdata[CB_EN];
        ctrl_q.rst_en     <= wdata[CB_RST];
        ctrl_q.irq_en     <= wdata[CB_IRQ];
        ctrl_q.tick_sel   <= wdata[CB_TSEL];
        ctrl_q.scope_full <= wdata[CB_SCOPE];
      end
    end
  end
endmodule

// File: rtl/wdog_tick.sv
module wdog_tick (
  input  logic sel_ext,
  input  logic ext_tick,
  output logic step
);
  assign step = sel_ext ? ext_tick : 1'b1;
endmodule

// File: rtl/wdog_count.sv
module wdog_count #(
  parameter int CNT_W = 32,
  parameter logic [CNT_W-1:0] CNT_RST = 32'h03EF_1480
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             step,
  input  logic             load,
  input  logic [CNT_W-1:0] reload,
  input  logic             irq_en,
  input  logic             rst_en,
  output logic [CNT_W-1:0] cnt,
  output logic             expire,
  output logic             irq,
  output logic             sys_rst
);
  logic at_zero;
  assign at_zero = (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= CNT_RST;
      expire  <= 1'b0;
      irq     <= 1'b0;
      sys_rst <= 1'b0;
    end else begin
      expire  <= 1'b0;
      irq     <= 1'b0;
      sys_rst <= 1'b0;
      if (load) begin
        cnt <= reload;
      end else if (run && step) begin
        if (at_zero) begin
          cnt     <= reload;
          expire  <= 1'b1;
          irq     <= irq_en;
          sys_rst <= rst_en;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/wdog_keyed_top.sv
module wdog_keyed_top
  import wdog_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32,
  parameter logic [DATA_W-1:0] RELOAD_RST = 32'h03EF_1480
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              tick_1mhz,
  output logic              expire_evt,
  output logic              irq_req,
  output logic              sys_rst_req,
  output logic              scope_full
);
  wd_ctrl_t          ctrl_q;
  logic [DATA_W-1:0] reload_q;
  logic              load_req;
  logic              step;
  logic              ctrl_en;
  logic [CNT_W-1:0]  cnt_q;

  wdog_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .RELOAD_RST(RELOAD_RST)
  ) u_regs (
    .clk(clk), .rst(rst), .addr(bus_addr), .wr(bus_wr), .wdata(bus_wdata),
    .cnt_val(cnt_q), .ctrl_q(ctrl_q), .reload_q(reload_q),
    .load_req(load_req), .rdata(bus_rdata)
  );

  wdog_tick u_tick (
    .sel_ext(ctrl_q.tick_sel), .ext_tick(tick_1mhz), .step(step)
  );

  wdog_count #(
    .CNT_W(CNT_W), .CNT_RST(CNT_W'(RELOAD_RST))
  ) u_count (
    .clk(clk), .rst(rst), .run(ctrl_q.en), .step(step), .load(load_req),
    .reload(CNT_W'(reload_q)), .irq_en(ctrl_q.irq_en), .rst_en(ctrl_q.rst_en),
    .cnt(cnt_q), .expire(expire_evt), .irq(irq_req), .sys_rst(sys_rst_req)
  );

  assign ctrl_en    = ctrl_q.en;
  assign scope_full = ctrl_q.scope_full;
endmodule

// File: rtl/wdog_keyed_chk.sv
module wdog_keyed_chk
  import wdog_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              expire_evt,
  input logic              irq_req,
  input logic              sys_rst_req,
  input logic              scope_full,
  input logic              ctrl_en,
  input logic              load_req,
  input logic [DATA_W-1:0] reload_q,
  input logic [CNT_W-1:0]  cnt_q
);
  AST_IRQ_WITH_EVT: assert property (@(posedge clk) disable iff (rst) irq_req |-> expire_evt); // R8
  AST_SYSRST_WITH_EVT: assert property (@(posedge clk) disable iff (rst) sys_rst_req |-> expire_evt); // R8
  AST_RESTART_READS_ZERO: assert property (@(posedge clk) disable iff (rst) ($past(bus_addr) == ADDR_W'(OFS_RESTART)) |-> (bus_rdata == '0)); // R2
  AST_EVT_NEEDS_RUN: assert property (@(posedge clk) disable iff (rst) expire_evt |-> $past(ctrl_en)); // R7
  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (rst) (!$past(ctrl_en) && !$past(load_req)) |-> $stable(cnt_q)); // R5
  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (rst) ($past(load_req) && !$past(rst)) |-> (cnt_q == CNT_W'($past(reload_q)))); // R4
  AST_SCOPE_TRACK: assert property (@(posedge clk) disable iff (rst) ($past(bus_wr && bus_addr == ADDR_W'(OFS_CTRL)) && !$past(rst)) |-> (scope_full == $past(bus_wdata[CB_SCOPE]))); // R10
endmodule

bind wdog_keyed_top wdog_keyed_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata), .expire_evt(expire_evt), .irq_req(irq_req),
  .sys_rst_req(sys_rst_req), .scope_full(scope_full), .ctrl_en(ctrl_en),
  .load_req(load_req), .reload_q(reload_q), .cnt_q(cnt_q)
);

// File: tb/wdog_keyed_top_test.sv
module wdog_keyed_top_test;
  localparam int AW = 4;
  localparam int DW = 32;
  localparam logic [AW-1:0] A_STATUS  = 4'h0;
  localparam logic [AW-1:0] A_RELOAD  = 4'h4;
  localparam logic [AW-1:0] A_RESTART = 4'h8;
  localparam logic [AW-1:0] A_CTRL    = 4'hC;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst = 1'b1;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_wr = 1'b0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic          tick_1mhz = 1'b0;
  logic          expire_evt, irq_req, sys_rst_req, scope_full;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  wdog_keyed_top uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_1mhz(tick_1mhz),
    .expire_evt(expire_evt), .irq_req(irq_req), .sys_rst_req(sys_rst_req),
    .scope_full(scope_full)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] v);
    bus_addr = a;
    @(posedge clk); @(negedge clk);
    v = bus_rdata;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog timeout actual=%0h expected=%0h", 0, 1);
    finish_run();
  end

  initial begin
    logic [DW-1:0] v, v2, frozen;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk(!expire_evt && !irq_req && !sys_rst_req && !scope_full, "R1 outputs after reset",
        {expire_evt, irq_req, sys_rst_req, scope_full}, 0);
    rd(A_STATUS, v);  chk(v == 32'h03EF1480, "R1 status", v, 32'h03EF1480);
    rd(A_RELOAD, v);  chk(v == 32'h03EF1480, "R1 reload", v, 32'h03EF1480);
    rd(A_CTRL, v);    chk(v == 0, "R1 control", v, 0);
    rd(A_RESTART, v); chk(v == 0, "R1 restart", v, 0);
    rd(4'h2, v);      chk(v == 0, "R2 unmapped read", v, 0);

    // R3 unused control bits not stored
    wr(A_CTRL, 32'hFFFF_FFC8);
    rd(A_CTRL, v); chk(v == 0, "R3 unused bits", v, 0);
    // R10 scope
    wr(A_CTRL, 32'h20);
    chk(scope_full == 1'b1, "R10 scope full", scope_full, 1);
    rd(A_CTRL, v); chk(v == 32'h20, "R3 scope bit readback", v, 32'h20);
    wr(A_CTRL, 32'h0);
    chk(scope_full == 1'b0, "R10 scope soc", scope_full, 0);

    // R7 R8 expiry period sweep, every-cycle count steps
    for (int n = 0; n <= 6; n++) begin
      for (int mode = 0; mode < 4; mode++) begin
        bit ie, re;
        ie = mode[0];
        re = mode[1];
        wr(A_RELOAD, n);
        wr(A_CTRL, 32'h1 | (32'(re) << 1) | (32'(ie) << 2));
        for (int k = 1; k <= 2 * (n + 1) + 1; k++) begin
          bit e;
          step();
          e = (k % (n + 1)) == 0;
          chk(expire_evt == e, "R7 expiry timing", expire_evt, e);
          chk(irq_req == (e && ie), "R8 irq pulse", irq_req, e && ie);
          chk(sys_rst_req == (e && re), "R8 reset pulse", sys_rst_req, e && re);
        end
        wr(A_CTRL, 32'h0);
      end
    end

    // R5 decrement by one per cycle, hold when disabled
    wr(A_RELOAD, 1000);
    wr(A_CTRL, 32'h1);
    rd(A_STATUS, v);
    for (int i = 0; i < 6; i++) begin
      step();
      chk(bus_rdata == v - 1, "R5 decrement by one", bus_rdata, v - 1);
      v = bus_rdata;
    end
    wr(A_CTRL, 32'h0);
    rd(A_STATUS, frozen);
    repeat (5) step();
    rd(A_STATUS, v);
    chk(v == frozen, "R5 hold when disabled", v, frozen);

    // R9 restart key, counter frozen
    wr(A_RESTART, 32'h4754);
    rd(A_STATUS, v); chk(v == frozen, "R9 wrong key ignored", v, frozen);
    wr(A_RESTART, 32'h1_4755);
    rd(A_STATUS, v); chk(v == frozen, "R9 upper bits ignored", v, frozen);
    wr(A_RELOAD, 77);
    rd(A_STATUS, v); chk(v == frozen, "R9 reload write alone", v, frozen);
    wr(A_RESTART, 32'h4755);
    rd(A_STATUS, v); chk(v == 77, "R9 key reloads", v, 77);

    // R9 periodic restarts keep the counter away from expiry
    wr(A_RELOAD, 3);
    wr(A_CTRL, 32'h7);
    for (int i = 0; i < 8; i++) begin
      wr(A_RESTART, 32'h4755);
      chk(!expire_evt, "R9 restart prevents expiry", expire_evt, 0);
      step();
      chk(!expire_evt, "R9 restart prevents expiry", expire_evt, 0);
      step();
      chk(!expire_evt, "R9 restart prevents expiry", expire_evt, 0);
    end
    wr(A_CTRL, 32'h0);

    // R4 enable rising edge loads, re-enable does not
    wr(A_RELOAD, 5);
    wr(A_CTRL, 32'h1);
    rd(A_STATUS, v); chk(v == 5, "R4 load on enable", v, 5);
    wr(A_CTRL, 32'h0);
    wr(A_RELOAD, 1000);
    wr(A_CTRL, 32'h1);
    repeat (10) step();
    wr(A_CTRL, 32'h1);
    rd(A_STATUS, v);
    chk(v < 990, "R4 no reload while enabled", v, 990);
    rd(A_STATUS, v2);
    chk(v2 == v - 1, "R5 still counting", v2, v - 1);
    wr(A_CTRL, 32'h0);

    // R6 external tick every third cycle
    for (int n = 0; n <= 3; n++) begin
      int ticks;
      wr(A_RELOAD, n);
      wr(A_CTRL, 32'h15);
      ticks = 0;
      for (int k = 1; k <= 6 * (n + 1) + 2; k++) begin
        bit e;
        tick_1mhz = (k % 3) == 0;
        @(posedge clk);
        if (tick_1mhz) ticks++;
        @(negedge clk);
        e = tick_1mhz && ((ticks % (n + 1)) == 0);
        chk(expire_evt == e, "R6 tick-paced expiry", expire_evt, e);
        chk(irq_req == e, "R8 irq with tick", irq_req, e);
      end
      tick_1mhz = 1'b0;
      wr(A_CTRL, 32'h0);
    end

    finish_run();
  end
endmodule